// File: doc/BRIEF.md
# Tone-Burst Sample-Count Checker

This block watches a stream of signed samples that should carry a repeating pattern: a tone burst of fixed length, then a stretch of silence of the same length, over and over. Noise corrupts the exact sample values, so the block does not check them. It checks the stream's timing instead. It sorts each valid sample into burst or silence by comparing its magnitude with a threshold. It then measures how long each burst lasts and records the sample index at which the burst begins.

Two checks run on every completed burst. The first compares the measured length with a programmed nominal length, allowing a programmed tolerance. The second compares the start index of burst k with the first burst's start plus k programmed periods. The expected position builds up from the first burst and is never re-anchored. A single lost or repeated sample therefore changes at most one burst length, but it shifts every later start position. Slow clock drift never upsets a length, and the position tolerance can be set wide enough to absorb it. The block reports each finished burst with a one-cycle pulse. It also keeps sticky error flags and an error counter for each kind of check.

Top module: `burst_slip_checker`

## Requirements
- R1: A valid sample is active when its two's-complement magnitude is strictly greater than `cfg_thresh`. A sample whose magnitude equals the threshold is inactive, and negative samples count by their magnitude.
- R2: A burst ends on the `cfg_holdoff`-th consecutive inactive valid sample after it starts. A holdoff of 0 behaves as 1. A shorter run of inactive samples inside a burst does not end it.
- R3: `burst_len` is the count of samples from the first active sample to the last active sample of the burst, inclusive. `burst_start` is that first sample's index, where indices count valid samples from 0 after reset. Both values appear with a one-cycle `burst_done` pulse in the cycle after the sample that ends the burst.
- R4: A cycle in which `in_valid` is low has no effect, whatever value is on `in_sample`.
- R5: `armed` stays low until the first active sample after reset. Before that sample, no `burst_done` pulse and no error is produced.
- R6: A completed burst with |`burst_len` − `cfg_len`| > `cfg_len_tol` raises `burst_len_bad` with its `burst_done` pulse. It also sets the sticky `len_err` flag and adds one to `len_err_cnt`.
- R7: Burst k (k ≥ 1) is expected to start at the first burst's start plus k·`cfg_period`. When |actual − expected| > `cfg_pos_tol`, that burst's `burst_done` pulse carries `burst_pos_bad`, `pos_err` is set, and `pos_err_cnt` goes up by one. The first burst never carries a position error.
- R8: `len_err` and `pos_err` stay set until reset, even while later bursts pass both checks.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DW | Signed sample |
| cfg_thresh | input | DW | Activity threshold (unsigned magnitude) |
| cfg_holdoff | input | HW | Inactive samples needed to end a burst |
| cfg_len | input | CW | Nominal burst length |
| cfg_len_tol | input | CW | Allowed length deviation |
| cfg_period | input | CW | Burst-to-burst period in samples |
| cfg_pos_tol | input | CW | Allowed start-position deviation |
| armed | output | 1 | First burst seen |
| burst_done | output | 1 | One-cycle pulse per completed burst |
| burst_len | output | CW | Measured length of that burst |
| burst_start | output | CW | Start index of that burst |
| burst_len_bad | output | 1 | That burst failed the length check |
| burst_pos_bad | output | 1 | That burst failed the position check |
| len_err | output | 1 | Sticky length-error flag |
| pos_err | output | 1 | Sticky position-error flag |
| len_err_cnt | output | CW | Length-error count (saturating) |
| pos_err_cnt | output | CW | Position-error count (saturating) |

## Verification
The hardest case to reach is a single-sample slip. It has to leave every burst length inside tolerance while shifting all later start positions. The bench deletes one tone sample from the middle of one burst and then checks two things. Each later burst carries a position error, so the error count grows by one per later burst rather than just once. The affected length is flagged by nothing. A second case adds one extra silence sample in each of two gaps, so the offset first sits inside a one-sample position tolerance and then moves past it. The remaining cases cover holdoff behaviour and valid-strobe gaps. In the holdoff case, a zero run inside a burst is first bridged and then, with a shorter holdoff, splits the burst. In the strobe case, idle cycles carry large values on the sample input.

// File: rtl/burst_slip_checker.sv
module burst_slip_checker #(
  parameter int DW = 16,
  parameter int CW = 32,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  input  logic [DW-1:0] cfg_thresh,
  input  logic [HW-1:0] cfg_holdoff,
  input  logic [CW-1:0] cfg_len,
  input  logic [CW-1:0] cfg_len_tol,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_pos_tol,
  output logic          armed,
  output logic          burst_done,
  output logic [CW-1:0] burst_len,
  output logic [CW-1:0] burst_start,
  output logic          burst_len_bad,
  output logic          burst_pos_bad,
  output logic          len_err,
  output logic          pos_err,
  output logic [CW-1:0] len_err_cnt,
  output logic [CW-1:0] pos_err_cnt
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [DW:0]   mag;
  logic          active;
  logic [CW-1:0] idx, run_len, run_start, exp_start;
  logic [HW-1:0] quiet, quiet_inc;
  logic          in_burst, run_pos_bad;
  logic          start_now, end_now;
  logic [CW-1:0] pdiff, pmag, ldiff, lmag;
  logic          pos_bad_now, len_bad_now;

  assign mag       = in_sample[DW-1] ? ({1'b0, ~in_sample} + 1'b1) : {1'b0, in_sample};
  assign active    = mag > {1'b0, cfg_thresh};
  assign quiet_inc = quiet + 1'b1;

  assign start_now = in_valid && !in_burst && active;
  assign end_now   = in_valid && in_burst && !active && (quiet_inc >= cfg_holdoff);

  assign pdiff       = idx - exp_start;
  assign pmag        = pdiff[CW-1] ? (~pdiff + 1'b1) : pdiff;
  assign pos_bad_now = armed && (pmag > cfg_pos_tol);

  assign ldiff       = run_len - cfg_len;
  assign lmag        = ldiff[CW-1] ? (~ldiff + 1'b1) : ldiff;
  assign len_bad_now = lmag > cfg_len_tol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx           <= '0;
      in_burst      <= 1'b0;
      run_len       <= '0;
      run_start     <= '0;
      exp_start     <= '0;
      quiet         <= '0;
      run_pos_bad   <= 1'b0;
      armed         <= 1'b0;
      burst_done    <= 1'b0;
      burst_len     <= '0;
      burst_start   <= '0;
      burst_len_bad <= 1'b0;
      burst_pos_bad <= 1'b0;
      len_err       <= 1'b0;
      pos_err       <= 1'b0;
      len_err_cnt   <= '0;
      pos_err_cnt   <= '0;
    end else begin
      burst_done <= end_now;
      if (in_valid) idx <= idx + 1'b1;

      if (start_now) begin
        in_burst    <= 1'b1;
        run_len     <= 1;
        quiet       <= '0;
        run_start   <= idx;
        run_pos_bad <= pos_bad_now;
        armed       <= 1'b1;
        exp_start   <= (armed ? exp_start : idx) + cfg_period;
      end else if (end_now) begin
        in_burst      <= 1'b0;
        quiet         <= '0;
        burst_len     <= run_len;
        burst_start   <= run_start;
        burst_len_bad <= len_bad_now;
        burst_pos_bad <= run_pos_bad;
        if (len_bad_now) begin
          len_err <= 1'b1;
          if (len_err_cnt != CNT_MAX) len_err_cnt <= len_err_cnt + 1'b1;
        end
        if (run_pos_bad) begin
          pos_err <= 1'b1;
          if (pos_err_cnt != CNT_MAX) pos_err_cnt <= pos_err_cnt + 1'b1;
        end
      end else if (in_valid && in_burst) begin
        if (active) begin
          run_len <= run_len + {{(CW-HW){1'b0}}, quiet} + 1'b1;
          quiet   <= '0;
        end else begin
          quiet <= quiet_inc;
        end
      end
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  // R3
  done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> burst_len != '0);

  // R5
  done_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> armed);

  // R5
  no_err_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !len_err && !pos_err && !burst_done);

  // R8
  len_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> len_err);

  // R8
  pos_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_err |=> pos_err);

  // R6
  len_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && burst_len_bad) |-> len_err);

  // R7
  pos_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pos_err) |-> burst_done && burst_pos_bad);

endmodule

// File: tb/burst_slip_checker_test.sv
module burst_slip_checker_test;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [15:0] in_sample = 0, cfg_thresh = 16'd100;
  logic [7:0]  cfg_holdoff = 8'd3;
  logic [31:0] cfg_len = 20, cfg_len_tol = 1, cfg_period = 40, cfg_pos_tol = 0;
  logic armed, burst_done, burst_len_bad, burst_pos_bad, len_err, pos_err;
  logic [31:0] burst_len, burst_start, len_err_cnt, pos_err_cnt;

  int total = 0, bad = 0, nrec = 0;
  bit gappy = 0;
  int rec_len[16], rec_start[16];
  bit rec_lb[16], rec_pb[16];

  always #2 clk = ~clk;

  burst_slip_checker uut (.*);

  always @(negedge clk) if (rst_n && burst_done && nrec < 16) begin
    rec_len[nrec] = burst_len; rec_start[nrec] = burst_start;
    rec_lb[nrec] = burst_len_bad; rec_pb[nrec] = burst_pos_bad;
    nrec++;
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", what, act, exp); end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; in_valid = 0; gappy = 0;
    repeat (3) @(negedge clk);
    nrec = 0; rst_n = 1;
  endtask

  task automatic send(input logic [15:0] v);
    @(negedge clk); in_valid = 1; in_sample = v;
    if (gappy) begin @(negedge clk); in_valid = 0; in_sample = 16'h7000; end
  endtask

  function automatic logic [15:0] tone(input int i);
    case (i % 4) 0, 1: return 16'd900; 2: return 16'd0; default: return -16'sd900; endcase
  endfunction

  task automatic send_tone(input int n, input int drop, input int zero);
    for (int i = 0; i < n; i++) if (i != drop) send(i == zero ? 16'd0 : tone(i));
  endtask

  task automatic send_gap(input int n);
    for (int i = 0; i < n; i++) send((i % 2) ? 16'd3 : -16'sd3);
  endtask

  task automatic finish_stream();
    @(negedge clk); in_valid = 0; repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_prearm();
    do_reset();
    chk(!armed && !burst_done && burst_len == 0 && !len_err && !pos_err &&
        len_err_cnt == 0 && pos_err_cnt == 0, "R9 reset state", armed, 0);
    send(16'd100); send(-16'sd100); send_gap(8);
    finish_stream();
    chk(!armed, "R1 R5 threshold-level samples do not arm", armed, 0);
    chk(nrec == 0 && !len_err && !pos_err, "R5 nothing before arming", nrec, 0);
  endtask

  task automatic t_nominal();
    do_reset(); cfg_pos_tol = 0; cfg_holdoff = 3; gappy = 1;
    send_gap(7);
    for (int b = 0; b < 3; b++) begin send_tone(20, -1, -1); send_gap(20); end
    finish_stream();
    chk(armed, "R5 armed after burst", armed, 1);
    chk(nrec == 3, "R4 burst count with idle cycles", nrec, 3);
    for (int b = 0; b < 3; b++) begin
      chk(rec_len[b] == 20, "R3 R4 burst length", rec_len[b], 20);
      chk(rec_start[b] == 7 + 40*b, "R3 burst start index", rec_start[b], 7 + 40*b);
    end
    chk(!len_err && !pos_err && len_err_cnt == 0 && pos_err_cnt == 0, "R6 R7 clean run", len_err_cnt + pos_err_cnt, 0);
  endtask

  task automatic t_slip();
    do_reset(); cfg_pos_tol = 0;
    send_gap(7);
    for (int b = 0; b < 4; b++) begin send_tone(20, b == 1 ? 5 : -1, -1); send_gap(20); end
    finish_stream();
    chk(nrec == 4, "R7 slip burst count", nrec, 4);
    chk(rec_len[1] == 19 && !rec_lb[1], "R6 one-sample slip within tolerance", rec_len[1], 19);
    chk(rec_start[2] == 86 && rec_start[3] == 126, "R7 shifted starts", rec_start[3], 126);
    chk(!rec_pb[1] && rec_pb[2] && rec_pb[3], "R7 per-burst position flags", rec_pb[2] + rec_pb[3], 2);
    chk(pos_err_cnt == 2 && pos_err && !len_err, "R7 cumulative position errors", pos_err_cnt, 2);
  endtask

  task automatic t_len();
    do_reset(); cfg_pos_tol = 0;
    send_gap(7);
    send_tone(20, -1, -1); send_gap(20);
    send_tone(24, -1, -1); send_gap(16);
    send_tone(20, -1, -1); send_gap(20);
    finish_stream();
    chk(rec_len[1] == 24 && rec_lb[1], "R6 long burst flagged", rec_len[1], 24);
    chk(!rec_lb[0] && !rec_lb[2], "R6 good bursts not flagged", rec_lb[0] + rec_lb[2], 0);
    chk(len_err && len_err_cnt == 1, "R6 length error count", len_err_cnt, 1);
    chk(len_err, "R8 length flag sticks after good burst", len_err, 1);
    chk(!pos_err, "R7 period preserved", pos_err, 0);
  endtask

  task automatic t_drift();
    do_reset(); cfg_pos_tol = 1;
    send_gap(7);
    for (int b = 0; b < 4; b++) begin send_tone(20, -1, -1); send_gap(b < 2 ? 21 : 20); end
    finish_stream();
    chk(rec_start[1] == 48 && !rec_pb[1], "R7 offset 1 within tolerance", rec_start[1], 48);
    chk(rec_start[2] == 89 && rec_pb[2], "R7 offset 2 flagged", rec_start[2], 89);
    chk(pos_err_cnt == 2, "R7 drift error count", pos_err_cnt, 2);
    chk(pos_err && !rec_pb[0], "R8 position flag held", pos_err, 1);
    cfg_pos_tol = 0;
  endtask

  task automatic t_holdoff();
    do_reset(); cfg_holdoff = 3;
    send_gap(7);
    for (int b = 0; b < 2; b++) begin send_tone(20, -1, 11); send_gap(20); end
    finish_stream();
    chk(nrec == 2 && rec_len[0] == 20 && rec_len[1] == 20, "R2 short zero run bridged", rec_len[0], 20);
    do_reset(); cfg_holdoff = 2;
    send_gap(7); send_tone(20, -1, 11); send_gap(20);
    finish_stream();
    chk(nrec == 2, "R2 holdoff 2 splits burst", nrec, 2);
    chk(rec_len[0] == 10 && rec_len[1] == 8, "R2 split lengths", rec_len[1], 8);
    cfg_holdoff = 3;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_prearm();
    t_nominal();
    t_slip();
    t_len();
    t_drift();
    t_holdoff();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule